// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a memory-mapped timer peripheral with four independent down-counters and one shared interrupt controller. Each counter has a prescaler that divides the clock by 1, 16 or 256. It counts at 16 or 32 bits and runs in one-shot, periodic or free-running mode. Software starts a countdown by writing the start value. It can queue a reload value that is used only when the counter next wraps. Because the count runs downward, software inverts the current value to get a rising time base.

Each counter sets its own raw event bit when it reaches zero. The raw bits are combined with an enable mask. The interrupt line is high while any enabled, pending event is present. Software clears pending events by writing ones to a clear register.

The bus port is synchronous. Writes take effect at the clock edge where `bus_we` is high. Read data is registered and appears one cycle after the address is presented.

Top module: `qtimer_unit`

## Requirements
- R1: After reset, every readable register (offsets 0x00 to 0x4C) reads zero and `irq_out` is low.
- R2: Address map, by byte address with bits [1:0] equal to zero:
  - 0x00 is the interrupt enable mask.
  - 0x04 is the raw event status.
  - 0x08 is the masked status.
  - 0x0C is the write-one-to-clear register.
  - Counter n has its registers at 0x10+0x10*n: start value at +0x0, current count at +0x4, control at +0x8, and reload value at +0xC.
  - Read data is valid one cycle after the address. The start value and reload value read back as written. Control bits [5:4] read zero. Unmapped or misaligned addresses read zero and ignore writes.
- R3: Control bit 7 enables the counter. Bits [3:2] select the clock divide: 00 gives 1, 01 gives 16, and 10 or 11 gives 256. An enabled counter decrements once every divide cycles. The prescaler restarts when the start value is written and when the counter goes from disabled to enabled.
- R4: In one-shot mode (control bit 0 = 1), a counter enabled with start value L reaches zero L*divide cycles after the enabling edge and sets its raw bit at that edge. It then stays at zero.
- R5: In periodic mode (bit 6 = 1, bit 0 = 0), the tick after zero reloads the reload value B. Later events are therefore (B+1)*divide cycles apart.
- R6: In free-running mode (bit 6 = 0, bit 0 = 0), the tick after zero loads all-ones at the selected width and counting continues.
- R7: Writing the reload value does not change the count in progress. The new value is used only at the next wrap.
- R8: With control bit 1 = 0 the counter is 16 bits wide. A written start value keeps only its low 16 bits, and the current count reads with its upper bits zero. With bit 1 = 1 it is 32 bits wide.
- R9: Raw bit n belongs to counter n. Writing the clear register clears exactly the bits written as 1. An event in the same cycle as its clear leaves the bit set.
- R10: The masked status is the raw status ANDed with the mask. `irq_out` is high when any masked status bit is set.
- R11: A disabled counter holds its value. A start-value write while disabled sets the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the address |
| irq_out | output | 1 | Combined interrupt, high while any enabled event is pending |

## Verification
The one-shot path is swept over every counter, two prescale settings and several start values. The measured cycle count to the interrupt separates a missing or extra decrement from an error in the prescaler restart. Periodic runs combine two reload values with two prescale settings, so a reload that skips the zero tick shows up as a gap that is too short. Free-running runs at both widths read the count just after zero, which tells the wrap-to-all-ones value apart from a reload. Mask and clear sequences with two counters pending show whether clearing or masking one bit disturbs the other.

// File: rtl/qtu_pkg.sv
package qtu_pkg;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] pre_sel;
        logic       wide;
        logic       oneshot;
    } qtu_ctrl_t;

    typedef enum logic [1:0] {
        SUB_START  = 2'd0,
        SUB_COUNT  = 2'd1,
        SUB_CTRL   = 2'd2,
        SUB_RELOAD = 2'd3
    } qtu_sub_e;

    typedef enum logic [1:0] {
        CMN_MASK   = 2'd0,
        CMN_RAW    = 2'd1,
        CMN_MASKED = 2'd2,
        CMN_CLEAR  = 2'd3
    } qtu_cmn_e;

    function automatic qtu_ctrl_t qtu_ctrl_unpack(input logic [7:0] b);
        qtu_ctrl_t c;
        c.en       = b[7];
        c.periodic = b[6];
        c.pre_sel  = b[3:2];
        c.wide     = b[1];
        c.oneshot  = b[0];
        return c;
    endfunction

    function automatic logic [7:0] qtu_ctrl_pack(input qtu_ctrl_t c);
        return {c.en, c.periodic, 2'b00, c.pre_sel, c.wide, c.oneshot};
    endfunction

endpackage

// File: rtl/qtu_channel.sv
module qtu_channel
    import qtu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int DIV_MID  = 16,
    parameter int DIV_HIGH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              reload_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] start_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic [7:0]        ctrl_o,
    output logic              zero_evt_o
);
    localparam int PRE_W = $clog2(DIV_HIGH);

    typedef struct packed {
        qtu_ctrl_t         ctrl;
        logic [DATA_W-1:0] start;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] cnt;
        logic [PRE_W-1:0]  pre;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] cur;
    logic [PRE_W-1:0]  pre_top;
    logic              tick;
    qtu_ctrl_t         new_ctrl;

    always_comb begin
        s_d        = s_q;
        zero_evt_o = 1'b0;
        width_mask = s_q.ctrl.wide ? {DATA_W{1'b1}} : DATA_W'({NARROW_W{1'b1}});
        case (s_q.ctrl.pre_sel)
            2'b00:   pre_top = '0;
            2'b01:   pre_top = PRE_W'(DIV_MID - 1);
            default: pre_top = PRE_W'(DIV_HIGH - 1);
        endcase
        tick     = s_q.ctrl.en && (s_q.pre == pre_top);
        cur      = s_q.cnt & width_mask;
        new_ctrl = qtu_ctrl_unpack(wdata[7:0]);

        if (s_q.ctrl.en) begin
            s_d.pre = tick ? '0 : s_q.pre + 1'b1;
        end

        if (tick) begin
            if (cur == '0) begin
                if (s_q.ctrl.oneshot) begin
                    s_d.cnt = cur;
                end else if (s_q.ctrl.periodic) begin
                    s_d.cnt = s_q.reload & width_mask;
                end else begin
                    s_d.cnt = width_mask;
                end
            end else begin
                s_d.cnt    = cur - 1'b1;
                zero_evt_o = (cur == DATA_W'(1)) && !start_we;
            end
        end

        if (ctrl_we) begin
            s_d.ctrl = new_ctrl;
            if (!(new_ctrl.en && s_q.ctrl.en)) begin
                s_d.pre = '0;
            end
        end
        if (reload_we) begin
            s_d.reload = wdata;
        end
        if (start_we) begin
            s_d.start = wdata;
            s_d.cnt   = wdata & width_mask;
            s_d.pre   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o  = s_q.start;
    assign reload_o = s_q.reload;
    assign count_o  = s_q.cnt & width_mask;
    assign ctrl_o   = qtu_ctrl_pack(s_q.ctrl);

endmodule

// File: rtl/qtu_irq_block.sv
module qtu_irq_block #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt_i,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [N_CH-1:0] wdata_i,
    output logic [N_CH-1:0] mask_o,
    output logic [N_CH-1:0] raw_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [N_CH-1:0] mask;
        logic [N_CH-1:0] raw;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we) begin
            s_d.mask = wdata_i;
        end
        s_d.raw = (s_q.raw & ~(clr_we ? wdata_i : '0)) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_o = s_q.mask;
    assign raw_o  = s_q.raw;
    assign irq_o  = |(s_q.raw & s_q.mask);

endmodule

// File: rtl/qtimer_unit.sv
module qtimer_unit
    import qtu_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int SLOT_W = ADDR_W - 4;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [SLOT_W-1:0]              slot;
    logic                           aligned;
    logic                           cmn_hit;
    qtu_sub_e                       sub;
    qtu_cmn_e                       cmn;
    logic [N_CH-1:0]                ch_hit;
    logic [N_CH-1:0]                st_we, rl_we, ct_we, ch_evt;
    logic [N_CH-1:0][DATA_W-1:0]    ch_start, ch_reload, ch_count;
    logic [N_CH-1:0][7:0]           ch_ctrl;
    logic [N_CH-1:0]                irq_mask, irq_raw;

    assign slot    = bus_addr[ADDR_W-1:4];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cmn_hit = aligned && (slot == '0);
    assign sub     = qtu_sub_e'(bus_addr[3:2]);
    assign cmn     = qtu_cmn_e'(bus_addr[3:2]);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign ch_hit[i] = aligned && (slot == SLOT_W'(i + 1));
        assign st_we[i]  = bus_we && ch_hit[i] && (sub == SUB_START);
        assign rl_we[i]  = bus_we && ch_hit[i] && (sub == SUB_RELOAD);
        assign ct_we[i]  = bus_we && ch_hit[i] && (sub == SUB_CTRL);

        qtu_channel #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_we   (st_we[i]),
            .reload_we  (rl_we[i]),
            .ctrl_we    (ct_we[i]),
            .wdata      (bus_wdata),
            .start_o    (ch_start[i]),
            .reload_o   (ch_reload[i]),
            .count_o    (ch_count[i]),
            .ctrl_o     (ch_ctrl[i]),
            .zero_evt_o (ch_evt[i])
        );
    end

    qtu_irq_block #(.N_CH(N_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (ch_evt),
        .mask_we (bus_we && cmn_hit && (cmn == CMN_MASK)),
        .clr_we  (bus_we && cmn_hit && (cmn == CMN_CLEAR)),
        .wdata_i (bus_wdata[N_CH-1:0]),
        .mask_o  (irq_mask),
        .raw_o   (irq_raw),
        .irq_o   (irq_out)
    );

    always_comb begin
        s_d.rdata = '0;
        if (cmn_hit) begin
            case (cmn)
                CMN_MASK:   s_d.rdata = DATA_W'(irq_mask);
                CMN_RAW:    s_d.rdata = DATA_W'(irq_raw);
                CMN_MASKED: s_d.rdata = DATA_W'(irq_raw & irq_mask);
                default:    s_d.rdata = '0;
            endcase
        end
        for (int i = 0; i < N_CH; i++) begin
            if (ch_hit[i]) begin
                case (sub)
                    SUB_START:  s_d.rdata = ch_start[i];
                    SUB_COUNT:  s_d.rdata = ch_count[i];
                    SUB_CTRL:   s_d.rdata = DATA_W'(ch_ctrl[i]);
                    default:    s_d.rdata = ch_reload[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;

endmodule

// File: rtl/qtu_checker.sv
module qtu_checker #(
    parameter int N_CH   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [N_CH-1:0]             raw_vec,
    input logic [N_CH-1:0]             mask_vec,
    input logic                        irq_out,
    input logic [N_CH-1:0][DATA_W-1:0] ch_count,
    input logic [N_CH-1:0][7:0]        ch_ctrl
);
    // R10: the line may only be high while some event source is enabled
    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (mask_vec != '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        logic wr_here;
        assign wr_here = bus_we && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(i + 1));

        // R9: a pending bit drops only after a clear write naming it
        assert_clear_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(raw_vec[i]) |-> $past(bus_we && bus_addr == ADDR_W'(12) && bus_wdata[i]));

        // R4: an event is raised exactly when the count has arrived at zero
        assert_event_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_vec[i]) |-> (ch_count[i] == '0));

        // R4: a one-shot counter at zero stays there unless software touches it
        assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[i][7] && ch_ctrl[i][0] && ch_count[i] == '0 && !wr_here)
            |=> (ch_count[i] == '0));

        // R11: a disabled counter does not move without a write
        assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[i][7] && !wr_here) |=> $stable(ch_count[i]));
    end

endmodule

bind qtimer_unit qtu_checker #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_vec   (irq_raw),
    .mask_vec  (irq_mask),
    .irq_out   (irq_out),
    .ch_count  (ch_count),
    .ch_ctrl   (ch_ctrl)
);

// File: tb/qtimer_unit_bench.sv
module qtimer_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qtimer_unit u_qtimer_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [7:0] ra(input int ch, input int sub);
        return 8'(16 + 16 * ch + 4 * sub);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk); #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int at);
        at = -1;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk); #1;
            if (irq_out) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic quiet_all();
        for (int c = 0; c < 4; c++) wr(ra(c, 2), 32'h0);
        wr(8'h0C, 32'hF);
    endtask

    task automatic arm(input int ch, input logic [31:0] start, input logic [31:0] reload,
                       input logic [7:0] ctrl, output int t0);
        wr(ra(ch, 2), 32'h0);
        wr(ra(ch, 0), start);
        wr(ra(ch, 3), reload);
        wr(8'h0C, 32'hF);
        wr(8'h00, 32'(1 << ch));
        wr(ra(ch, 2), 32'(ctrl));
        t0 = cyc;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0, at, at2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(irq_out == 1'b0, "R1 irq after reset", 32'(irq_out), 0);
        for (int a = 0; a <= 8'h4C; a += 4) begin
            rd(8'(a), v);
            chk(v == 0, "R1 register reset value", v, 0);
        end

        // R2: readback and map
        for (int c = 0; c < 4; c++) begin
            wr(ra(c, 0), 32'hA000_0000 | 32'(c * 32'h111));
            wr(ra(c, 3), 32'h5000_0000 + 32'(c));
            wr(ra(c, 2), 32'h3F);
        end
        for (int c = 0; c < 4; c++) begin
            rd(ra(c, 0), v); chk(v == (32'hA000_0000 | 32'(c * 32'h111)), "R2 start readback", v, 32'hA000_0000 | 32'(c * 32'h111));
            rd(ra(c, 3), v); chk(v == 32'h5000_0000 + 32'(c), "R2 reload readback", v, 32'h5000_0000 + 32'(c));
            rd(ra(c, 2), v); chk(v == 32'h0F, "R2 ctrl readback", v, 32'h0F);
        end
        wr(8'h11, 32'h7);
        rd(8'h10, v); chk(v == 32'hA000_0000, "R2 misaligned write ignored", v, 32'hA000_0000);
        rd(8'h50, v); chk(v == 0, "R2 unmapped read", v, 0);

        // R11: disabled counter holds the written start value
        wr(ra(3, 2), 32'h02);
        wr(ra(3, 0), 32'd9);
        repeat (5) @(posedge clk);
        rd(ra(3, 1), v); chk(v == 9, "R11 disabled hold", v, 9);

        // R3/R4: one-shot sweep over counters, prescale and start value
        for (int c = 0; c < 4; c++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int li = 0; li < 3; li++) begin
                    int l, dv;
                    l  = (li == 0) ? 1 : (li == 1) ? 2 : 5;
                    dv = sel ? 16 : 1;
                    arm(c, 32'(l), 0, 8'(8'h83 | (sel << 2)), t0);
                    wait_irq(at);
                    chk(at - t0 == l * dv, "R4 one-shot cycles to zero", 32'(at - t0), 32'(l * dv));
                    repeat (3) @(posedge clk);
                    rd(ra(c, 1), v); chk(v == 0, "R4 one-shot stays at zero", v, 0);
                end
            end
        end

        // R3: large divide settings
        arm(0, 32'd2, 0, 8'h8B, t0);
        wait_irq(at); chk(at - t0 == 512, "R3 divide 256", 32'(at - t0), 512);
        arm(1, 32'd1, 0, 8'h8F, t0);
        wait_irq(at); chk(at - t0 == 256, "R3 select 11 divides by 256", 32'(at - t0), 256);

        // R8: narrow one-shot uses only the low half of the start value
        arm(2, 32'h0001_0003, 0, 8'h81, t0);
        wait_irq(at); chk(at - t0 == 3, "R8 narrow start value", 32'(at - t0), 3);
        wr(ra(2, 2), 32'h0);
        wr(ra(2, 0), 32'h0012_3456);
        rd(ra(2, 1), v); chk(v == 32'h3456, "R8 narrow count readback", v, 32'h3456);

        // R5: periodic sweep
        quiet_all();
        for (int c = 1; c < 3; c++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int bi = 0; bi < 2; bi++) begin
                    int b, dv;
                    b  = bi ? 3 : 1;
                    dv = sel ? 16 : 1;
                    arm(c, 32'd4, 32'(b), 8'(8'hC2 | (sel << 2)), t0);
                    wait_irq(at);
                    chk(at - t0 == 4 * dv, "R5 periodic first event", 32'(at - t0), 32'(4 * dv));
                    wr(8'h0C, 32'(1 << c));
                    wait_irq(at2);
                    chk(at2 - at == (b + 1) * dv, "R5 periodic event gap", 32'(at2 - at), 32'((b + 1) * dv));
                    wr(ra(c, 2), 32'h0);
                end
            end
        end

        // R7: reload write during a count applies only at the wrap
        arm(3, 32'd10, 32'd4, 8'hC2, t0);
        wr(ra(3, 3), 32'd6);
        wait_irq(at); chk(at - t0 == 10, "R7 running count unaffected", 32'(at - t0), 10);
        wr(8'h0C, 32'h8);
        wait_irq(at2); chk(at2 - at == 7, "R7 new reload used at wrap", 32'(at2 - at), 7);
        wr(ra(3, 2), 32'h0);

        // R6: free-running wrap at both widths
        arm(2, 32'd2, 0, 8'h80, t0);
        wait_irq(at);
        rd(ra(2, 1), v);
        rd(ra(2, 1), v); chk(v == 32'hFFFF, "R6 narrow wrap", v, 32'hFFFF);
        rd(ra(2, 1), v); chk(v == 32'hFFFE, "R6 narrow continues", v, 32'hFFFE);
        arm(2, 32'd2, 0, 8'h82, t0);
        wait_irq(at);
        rd(ra(2, 1), v);
        rd(ra(2, 1), v); chk(v == 32'hFFFF_FFFF, "R6 wide wrap", v, 32'hFFFF_FFFF);
        wr(ra(2, 2), 32'h0);

        // R9/R10: mask and clear
        quiet_all();
        wr(8'h00, 32'h0);
        wr(ra(0, 0), 32'd3);
        wr(ra(0, 2), 32'h83);
        repeat (6) @(posedge clk); #1;
        chk(irq_out == 1'b0, "R10 masked event keeps line low", 32'(irq_out), 0);
        rd(8'h04, v); chk(v == 1, "R9 raw bit of counter 0", v, 1);
        rd(8'h08, v); chk(v == 0, "R10 masked status with mask clear", v, 0);
        wr(8'h00, 32'h1);
        chk(irq_out == 1'b1, "R10 mask enables line", 32'(irq_out), 1);
        rd(8'h08, v); chk(v == 1, "R10 masked status", v, 1);
        wr(ra(1, 0), 32'd2);
        wr(ra(1, 2), 32'h83);
        repeat (4) @(posedge clk);
        rd(8'h04, v); chk(v == 3, "R9 two pending bits", v, 3);
        wr(8'h0C, 32'h2);
        rd(8'h04, v); chk(v == 1, "R9 clear only written bit", v, 1);
        chk(irq_out == 1'b1, "R10 line held by other bit", 32'(irq_out), 1);
        wr(8'h0C, 32'h1);
        chk(irq_out == 1'b0, "R10 line drops after clear", 32'(irq_out), 0);
        rd(8'h04, v); chk(v == 0, "R9 all cleared", v, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule